// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns single-beat requests from an internal master into complete read or write cycles on an external parallel memory bus. A request carries an address, write data, a write flag and per-byte enables. The sequencer then steps through an address-latch phase, an optional strobe delay, a strobe phase and a recovery phase. At the end of a read it hands the captured data back with a one-cycle completion pulse.

The bus can share its data pins with the low address bits (multiplexed) or keep them separate (demultiplexed). It can be one byte lane wide or two. That gives four access modes. The length of each phase is set by configuration inputs:

- a longer latch pulse;
- an inverted wait-state code;
- an extra cycle before the strobe;
- a skip bit for the recovery gap;
- a ready handshake with a selectable active level.

One clock cycle of the sequencer stands for one timing unit of the bus.

Top module: `xbus_cycle_seq`

## Requirements
- R1: While `bus_ale` is high, `bus_addr` equals the request address. In multiplexed mode (`cfg_mux`=1), `bus_ad_out` carries the low 16 address bits with `bus_ad_oe`=2'b11. In demultiplexed mode, `bus_ad_oe` is 2'b00 during that phase.
- R2: `bus_ale` is high for exactly 1 cycle after a request is accepted, or for 2 cycles when `cfg_ale_ext`=1. No strobe is low while `bus_ale` is high.
- R3: With the ready handshake off (`cfg_rdy_en`=0), the strobe stays low for 1 + 2*(15 - `cfg_wait`) cycles. So a code of 15 gives a single strobe cycle.
- R4: With `cfg_rw_dly`=1, exactly one cycle lies between the fall of `bus_ale` and the start of the strobe. `bus_cs_n` is low in that cycle. With `cfg_rw_dly`=0, the strobe follows the latch phase directly.
- R5: After the strobe rises, `req_ready` stays low for 2 more cycles when `cfg_tri_skip`=0. It is high in the first cycle after the strobe when `cfg_tri_skip`=1.
- R6: With `cfg_rdy_en`=1, `bus_ready` is sampled on the clock edge that ends the last programmed strobe cycle. It counts as active when it equals `cfg_rdy_pol`. When it is inactive, the strobe is extended by 2 cycles and `bus_ready` is sampled again.
- R7: In a write, only `bus_wr_n` goes low. From the delay cycle through the strobe, `bus_ad_out` carries the write data and `bus_ad_oe` equals `req_be` masked to lane 0 in 8-bit mode (`cfg_wide`=0).
- R8: In a read, only `bus_rd_n` goes low and `bus_ad_oe` is 2'b00 after the latch phase. `rsp_done` pulses for one cycle in the first cycle after the strobe. `rsp_rdata` then holds `bus_ad_in` as sampled on the edge that ends the strobe, with the upper byte forced to zero in 8-bit mode.
- R9: `bus_cs_n` is low from the latch phase through the strobe, and high otherwise. While it is low, `bus_bhe_n` is the inverse of `req_be[1]` in 16-bit mode and stays 1 in 8-bit mode.
- R10: One clock edge with `rst_n` low, even in the middle of a cycle, leaves `bus_ale`=0, `bus_rd_n`=`bus_wr_n`=`bus_cs_n`=1, `bus_ad_oe`=0, `req_ready`=1 and `rsp_done`=0.
- R11: A request is accepted only while `req_ready` is high. A `req_valid` held high through a running cycle starts no second latch phase before `req_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one bus timing unit |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mux | input | 1 | 1: address and data share `bus_ad_*` |
| cfg_wide | input | 1 | 1: 16-bit data bus, 0: 8-bit |
| cfg_ale_ext | input | 1 | Lengthen the latch pulse by one cycle |
| cfg_wait | input | 4 | Inverted wait-state code (15 = no wait) |
| cfg_rw_dly | input | 1 | Insert one cycle before the strobe |
| cfg_tri_skip | input | 1 | Remove the recovery gap |
| cfg_rdy_en | input | 1 | Enable the ready handshake |
| cfg_rdy_pol | input | 1 | Active level of `bus_ready` |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this edge |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| req_we | input | 1 | 1: write, 0: read |
| req_be | input | 2 | Byte enables, bit 1 = high lane |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` |
| bus_addr | output | 24 | Full address lines |
| bus_ad_out | output | 16 | Shared/data bus output value |
| bus_ad_oe | output | 2 | Per-lane output enable of `bus_ad_out` |
| bus_ad_in | input | 16 | Shared/data bus input value |
| bus_ale | output | 1 | Address latch enable |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_bhe_n | output | 1 | High byte enable, active low |
| bus_ready | input | 1 | Ready handshake from the memory |

## Verification
The properties assume that the configuration inputs change only while `req_ready` is high. They also assume that `bus_ready` and `bus_ad_in` are already synchronous to `clk`. Under these assumptions, the phase lengths and the single-strobe and no-drive-during-read relations follow from one consistent setting per cycle. The stimulus writes all configuration fields together with the request in the idle cycle and holds them until the next request. `bus_ready` and `bus_ad_in` are driven only on falling clock edges, from a count of strobe cycles already seen.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus cycle sequencer.
package xbus_pkg;

    // Phase of one external bus cycle.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ALE  = 3'd1,
        PH_DLY  = 3'd2,
        PH_STB  = 3'd3,
        PH_TRI  = 3'd4
    } phase_t;

endpackage

// File: rtl/xbus_ready_qual.sv
// Qualifies the external ready input.
// Assumes bus_ready is already synchronous to clk.
// With the handshake disabled, the programmed length always counts as complete.
module xbus_ready_qual (
    input  logic rdy_en,
    input  logic rdy_pol,
    input  logic bus_ready,
    output logic rdy_ok
);

    // Active when disabled, or when the input level matches the polarity.
    always_comb begin
        rdy_ok = !rdy_en || (bus_ready == rdy_pol);
    end

endmodule

// File: rtl/xbus_phase_ctl.sv
// Phase sequencer with one down-counter for all phase lengths.
// Assumes configuration is stable while a cycle runs.
// One clock cycle is one timing unit.
module xbus_phase_ctl
    import xbus_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ale_ext,
    input  logic              rw_dly,
    input  logic              tri_skip,
    input  logic [WAIT_W-1:0] wait_code,
    input  logic              rdy_ok,
    output phase_t            phase,
    output logic              strobe_end
);

    localparam int CNT_W = WAIT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] stb_reload;
    logic             last_unit;

    // Extra strobe units: twice the inverted wait code.
    always_comb begin
        stb_reload = {~wait_code, 1'b0};
        last_unit  = (cnt_q == '0);
        strobe_end = (phase == PH_STB) && last_unit && rdy_ok;
    end

    // Phase transitions and counter loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_ALE;
                        cnt_q <= ale_ext ? CNT_W'(1) : '0;
                    end
                end
                PH_ALE: begin
                    if (!last_unit) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (rw_dly) begin
                        phase <= PH_DLY;
                    end else begin
                        phase <= PH_STB;
                        cnt_q <= stb_reload;
                    end
                end
                PH_DLY: begin
                    phase <= PH_STB;
                    cnt_q <= stb_reload;
                end
                PH_STB: begin
                    if (!last_unit) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (!rdy_ok) begin
                        cnt_q <= CNT_W'(1);
                    end else if (tri_skip) begin
                        phase <= PH_IDLE;
                    end else begin
                        phase <= PH_TRI;
                        cnt_q <= CNT_W'(1);
                    end
                end
                PH_TRI: begin
                    if (!last_unit) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/xbus_lane_path.sv
// Request latch, bus drive decode and read capture.
// Assumes DATA_W is a multiple of 8 with at least two lanes.
// Lane 0 is always active; the upper lanes are used only in 16-bit mode.
module xbus_lane_path
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  phase_t                phase,
    input  logic                  strobe_end,
    input  logic                  cfg_mux,
    input  logic                  cfg_wide,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  req_we,
    input  logic [DATA_W/8-1:0]   req_be,
    input  logic [DATA_W-1:0]     bus_ad_in,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_ad_out,
    output logic [DATA_W/8-1:0]   bus_ad_oe,
    output logic                  bus_ale,
    output logic                  bus_cs_n,
    output logic                  bus_rd_n,
    output logic                  bus_wr_n,
    output logic                  bus_bhe_n,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata
);

    localparam int LANES = DATA_W / 8;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic [LANES-1:0]  be_q;
    logic [LANES-1:0]  lane_on;
    logic [DATA_W-1:0] lane_rd;
    logic              in_cycle;
    logic              addr_drive;
    logic              data_drive;

    // Per-lane enable and read-data masking.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_base
            assign lane_on[g] = 1'b1;
        end else begin : g_upper
            assign lane_on[g] = cfg_wide;
        end
        assign lane_rd[g*8 +: 8] = lane_on[g] ? bus_ad_in[g*8 +: 8] : 8'h00;
    end

    // Latch the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            we_q    <= req_we;
            be_q    <= req_be;
        end
    end

    // Decode bus controls from the current phase.
    always_comb begin
        in_cycle   = (phase == PH_ALE) || (phase == PH_DLY) || (phase == PH_STB);
        addr_drive = cfg_mux && (phase == PH_ALE);
        data_drive = we_q && ((phase == PH_DLY) || (phase == PH_STB));
        bus_addr   = addr_q;
        bus_ale    = (phase == PH_ALE);
        bus_cs_n   = !in_cycle;
        bus_rd_n   = !((phase == PH_STB) && !we_q);
        bus_wr_n   = !((phase == PH_STB) && we_q);
        bus_bhe_n  = !(in_cycle && cfg_wide && be_q[LANES-1]);
        if (addr_drive) begin
            bus_ad_out = addr_q[DATA_W-1:0];
            bus_ad_oe  = '1;
        end else begin
            bus_ad_out = wdata_q;
            bus_ad_oe  = data_drive ? (be_q & lane_on) : '0;
        end
    end

    // Capture read data and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= strobe_end;
            if (strobe_end && !we_q) begin
                rsp_rdata <= lane_rd;
            end
        end
    end

endmodule

// File: rtl/xbus_cycle_seq.sv
// External memory bus cycle sequencer (top).
// Accepts one request while idle and runs a full bus cycle: latch, optional
// delay, strobe with wait states and ready extension, then recovery.
// Assumes configuration changes only while req_ready is high.
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_mux,
    input  logic                cfg_wide,
    input  logic                cfg_ale_ext,
    input  logic [WAIT_W-1:0]   cfg_wait,
    input  logic                cfg_rw_dly,
    input  logic                cfg_tri_skip,
    input  logic                cfg_rdy_en,
    input  logic                cfg_rdy_pol,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_we,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_ad_out,
    output logic [DATA_W/8-1:0] bus_ad_oe,
    input  logic [DATA_W-1:0]   bus_ad_in,
    output logic                bus_ale,
    output logic                bus_cs_n,
    output logic                bus_rd_n,
    output logic                bus_wr_n,
    output logic                bus_bhe_n,
    input  logic                bus_ready
);

    phase_t phase;
    logic   start;
    logic   rdy_ok;
    logic   strobe_end;

    // Accept a request only in the idle phase.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        start     = req_ready && req_valid;
    end

    xbus_ready_qual u_rdy (
        .rdy_en    (cfg_rdy_en),
        .rdy_pol   (cfg_rdy_pol),
        .bus_ready (bus_ready),
        .rdy_ok    (rdy_ok)
    );

    xbus_phase_ctl #(.WAIT_W(WAIT_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ale_ext    (cfg_ale_ext),
        .rw_dly     (cfg_rw_dly),
        .tri_skip   (cfg_tri_skip),
        .wait_code  (cfg_wait),
        .rdy_ok     (rdy_ok),
        .phase      (phase),
        .strobe_end (strobe_end)
    );

    xbus_lane_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase      (phase),
        .strobe_end (strobe_end),
        .cfg_mux    (cfg_mux),
        .cfg_wide   (cfg_wide),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_we     (req_we),
        .req_be     (req_be),
        .bus_ad_in  (bus_ad_in),
        .bus_addr   (bus_addr),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_ale    (bus_ale),
        .bus_cs_n   (bus_cs_n),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_bhe_n  (bus_bhe_n),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/xbus_cycle_seq_chk.sv
// Checker bound to the sequencer top.
// It relates the strobes, chip select, latch enable and completion pulse.
module xbus_cycle_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                rsp_done,
    input logic [DATA_W/8-1:0] bus_ad_oe,
    input logic                bus_ale,
    input logic                bus_cs_n,
    input logic                bus_rd_n,
    input logic                bus_wr_n
);

    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (bus_cs_n && bus_rd_n && bus_wr_n && !bus_ale && req_ready && !rsp_done));

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    a_r9_cs_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

    a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_rd_n && bus_wr_n && !bus_cs_n));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r8_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(!bus_rd_n || !bus_wr_n));

    a_r8_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (bus_ad_oe == '0));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && !bus_ale));

    a_r11_ale_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ale) |-> $past(req_ready));

endmodule

bind xbus_cycle_seq xbus_cycle_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_ad_oe (bus_ad_oe),
    .bus_ale   (bus_ale),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n)
);

// File: tb/xbus_cycle_seq_tb.sv
module xbus_cycle_seq_tb;

    typedef struct packed {
        logic        mux;
        logic        wide;
        logic        ext;
        logic [3:0]  ws;
        logic        dly;
        logic        tskip;
        logic        rdy_en;
        logic        pol;
        logic        we;
        logic [1:0]  be;
        logic [23:0] addr;
        logic [15:0] wdata;
        logic [15:0] rdval;
        logic [5:0]  hold;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b0,4'd15,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,24'h123456,16'h0000,16'hA5C3,6'd0},
        '{1'b1,1'b1,1'b1,4'd14,1'b1,1'b0,1'b0,1'b0,1'b1,2'b11,24'h00BEEF,16'h1234,16'h0000,6'd0},
        '{1'b0,1'b1,1'b0,4'd13,1'b0,1'b1,1'b0,1'b0,1'b0,2'b01,24'hFF0002,16'h0000,16'h5AA5,6'd0},
        '{1'b0,1'b0,1'b0,4'd15,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,24'h000100,16'h0000,16'h77EE,6'd0},
        '{1'b1,1'b0,1'b0,4'd15,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,24'h0A0B0C,16'hC0DE,16'h0000,6'd0},
        '{1'b1,1'b1,1'b0,4'd15,1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,24'h330044,16'h0000,16'h0F0F,6'd2},
        '{1'b0,1'b1,1'b0,4'd14,1'b0,1'b1,1'b1,1'b0,1'b1,2'b11,24'h440055,16'h9988,16'h0000,6'd6},
        '{1'b1,1'b1,1'b1,4'd12,1'b1,1'b0,1'b1,1'b1,1'b0,2'b10,24'h556677,16'h0000,16'hBEAD,6'd0},
        '{1'b0,1'b1,1'b1,4'd0, 1'b1,1'b1,1'b0,1'b0,1'b0,2'b11,24'hABCDEF,16'h0000,16'h6C6C,6'd0},
        '{1'b0,1'b1,1'b0,4'd15,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,24'h00F00D,16'hFACE,16'h0000,6'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mux = 1'b0, cfg_wide = 1'b1, cfg_ale_ext = 1'b0;
    logic [3:0]  cfg_wait = 4'd15;
    logic        cfg_rw_dly = 1'b0, cfg_tri_skip = 1'b0, cfg_rdy_en = 1'b0, cfg_rdy_pol = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_we = 1'b0;
    logic [1:0]  req_be = 2'b11;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [23:0] bus_addr;
    logic [15:0] bus_ad_out;
    logic [1:0]  bus_ad_oe;
    logic [15:0] bus_ad_in = 16'hDEAD;
    logic        bus_ale, bus_cs_n, bus_rd_n, bus_wr_n, bus_bhe_n;
    logic        bus_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    xbus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_mux(cfg_mux), .cfg_wide(cfg_wide), .cfg_ale_ext(cfg_ale_ext),
        .cfg_wait(cfg_wait), .cfg_rw_dly(cfg_rw_dly), .cfg_tri_skip(cfg_tri_skip),
        .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_pol(cfg_rdy_pol),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_we(req_we), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_bhe_n(bus_bhe_n),
        .bus_ready(bus_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int ale_n = 0, dly_n = 0, stb_n = 0, tri_n = 0, done_n = 0;
        bit addr_bad = 0, drv_bad = 0, wrong_stb = 0, bhe_bad = 0, early_done = 0, finished = 0;
        logic [15:0] got = '0;
        logic [1:0]  exp_mask = v.be & (v.wide ? 2'b11 : 2'b01);
        logic        exp_bhe = !(v.wide && v.be[1]);
        logic [15:0] exp_rd = v.wide ? v.rdval : {8'h00, v.rdval[7:0]};
        int b = 1 + 2 * (15 - int'(v.ws));
        int e = b;
        if (v.rdy_en) while (!(e > int'(v.hold))) e += 2;
        @(negedge clk);
        cfg_mux = v.mux; cfg_wide = v.wide; cfg_ale_ext = v.ext; cfg_wait = v.ws;
        cfg_rw_dly = v.dly; cfg_tri_skip = v.tskip; cfg_rdy_en = v.rdy_en; cfg_rdy_pol = v.pol;
        req_addr = v.addr; req_wdata = v.wdata; req_we = v.we; req_be = v.be;
        bus_ready = ~v.pol; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            bus_ad_in = 16'hDEAD;
            bus_ready = ~v.pol;
            if (bus_ale) begin
                ale_n++;
                if (bus_addr != v.addr) addr_bad = 1;
                if (v.mux && (bus_ad_out != v.addr[15:0] || bus_ad_oe != 2'b11)) addr_bad = 1;
                if (!v.mux && bus_ad_oe != 2'b00) addr_bad = 1;
                if (rsp_done) early_done = 1;
            end else if (!bus_rd_n || !bus_wr_n) begin
                stb_n++;
                if (v.we) begin
                    if (!bus_rd_n || bus_wr_n) wrong_stb = 1;
                    if (bus_ad_oe != exp_mask || bus_ad_out != v.wdata) drv_bad = 1;
                end else begin
                    if (!bus_wr_n || bus_rd_n) wrong_stb = 1;
                    if (bus_ad_oe != 2'b00) drv_bad = 1;
                end
                if (bus_bhe_n != exp_bhe || bus_cs_n) bhe_bad = 1;
                if (rsp_done) early_done = 1;
                bus_ad_in = v.rdval;
                bus_ready = (stb_n > int'(v.hold)) ? v.pol : ~v.pol;
            end else if (stb_n == 0) begin
                if (!bus_cs_n) dly_n++;
                if (v.we && bus_ad_oe != exp_mask) drv_bad = 1;
                if (!v.we && bus_ad_oe != 2'b00) drv_bad = 1;
            end else begin
                if (!bus_cs_n || bus_bhe_n != 1'b1) bhe_bad = 1;
                if (rsp_done) begin done_n++; got = rsp_rdata; end
                if (req_ready) begin finished = 1; break; end
                tri_n++;
            end
            @(negedge clk);
        end
        bus_ad_in = 16'hDEAD;
        chk(finished, $sformatf("R5 vec%0d cycle never returned to idle", idx), 0, 1);
        chk(ale_n == 1 + int'(v.ext), $sformatf("R2 vec%0d ALE length", idx), ale_n, 1 + v.ext);
        chk(!addr_bad, $sformatf("R1 vec%0d address phase", idx), addr_bad, 0);
        chk(dly_n == int'(v.dly), $sformatf("R4 vec%0d delay cycles", idx), dly_n, v.dly);
        if (v.rdy_en) chk(stb_n == e, $sformatf("R6 vec%0d ready-extended strobe", idx), stb_n, e);
        else          chk(stb_n == e, $sformatf("R3 vec%0d strobe length", idx), stb_n, e);
        if (v.we) chk(!drv_bad, $sformatf("R7 vec%0d write data drive", idx), drv_bad, 0);
        else      chk(!drv_bad, $sformatf("R8 vec%0d read bus released", idx), drv_bad, 0);
        chk(!wrong_stb, $sformatf("R7 R8 vec%0d strobe selection", idx), wrong_stb, 0);
        chk(!bhe_bad, $sformatf("R9 vec%0d chip select / high byte enable", idx), bhe_bad, 0);
        chk(tri_n == (v.tskip ? 0 : 2), $sformatf("R5 vec%0d recovery", idx), tri_n, v.tskip ? 0 : 2);
        chk(done_n == 1 && !early_done, $sformatf("R8 vec%0d done pulse count", idx), done_n, 1);
        if (!v.we) chk(got == exp_rd, $sformatf("R8 vec%0d read data", idx), got, exp_rd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: state under reset
        chk(!bus_ale && bus_rd_n && bus_wr_n && bus_cs_n && bus_ad_oe == 2'b00 && req_ready && !rsp_done,
            "R10 reset state", {bus_ale, bus_rd_n, bus_wr_n, bus_cs_n, req_ready, rsp_done}, 6'b011110);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // R11: request held high during a running cycle
        begin
            int rises = 0;
            bit busy_ok = 1;
            logic prev_ale = 1'b0;
            @(negedge clk);
            cfg_mux = 1'b1; cfg_wide = 1'b1; cfg_ale_ext = 1'b0; cfg_wait = 4'd15;
            cfg_rw_dly = 1'b0; cfg_tri_skip = 1'b0; cfg_rdy_en = 1'b0;
            req_we = 1'b0; req_addr = 24'h111111; req_valid = 1'b1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (bus_ale && !prev_ale) rises++;
                prev_ale = bus_ale;
                if (req_ready) busy_ok = 0;
                req_addr = 24'h222222;
            end
            req_valid = 1'b0;
            chk(rises == 1, "R11 single latch phase while busy", rises, 1);
            chk(busy_ok, "R11 req_ready low while busy", busy_ok, 1);
            repeat (3) @(negedge clk);
            chk(bus_cs_n && req_ready, "R11 no second cycle", {bus_cs_n, req_ready}, 2'b11);
        end

        // R10: reset in the middle of a long strobe
        begin
            @(negedge clk);
            cfg_wait = 4'd0; cfg_mux = 1'b0; req_we = 1'b1; req_be = 2'b11; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (4) @(negedge clk);
            chk(!bus_wr_n, "R3 strobe running before reset", bus_wr_n, 0);
            rst_n = 1'b0;
            @(negedge clk);
            chk(bus_wr_n && bus_rd_n && bus_cs_n && !bus_ale && bus_ad_oe == 2'b00 && req_ready && !rsp_done,
                "R10 mid-cycle reset", {bus_wr_n, bus_cs_n, bus_ad_oe, req_ready}, 5'b11001);
            rst_n = 1'b1;
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule